// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 262,144 four-bit words. The RAM has active-low select, output-enable and write-strobe pins and one shared four-bit data bus. The host places a single read or write request with a valid flag, a direction bit, an 18-bit address and a write nibble. The block then drives the RAM pins through the required phases and returns one acknowledge pulse. For a read, that pulse carries the captured nibble.

Every phase is a whole number of clock cycles. These counts are derived at elaboration from the clock period and the RAM's minimum times in nanoseconds. Each count is a ceiling division with a floor of one cycle.

The data bus is split at the block's edge into an output nibble, a drive-enable and an input nibble. A pad outside the block joins them.

The block keeps the RAM deselected, and therefore in standby, while it is idle. It never turns on its own drivers while the RAM may still be driving the bus.

Top module: `asram_ctrl`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a cycle, forces select, output-enable and write-strobe high, drive-enable low, acknowledge low and the read nibble to 0 on the next clock edge.
- R2: While no request is in progress, select is high, the other strobes are high and drive-enable is low.
- R3: A read holds select and output-enable low, with write-strobe high, for N_RD = max(ceil(tRC), ceil(tAA), ceil(tOE)) cycles, which is 5 at a 4 ns clock. The RAM address stays constant for the whole time select is low.
- R4: The read nibble is sampled on the edge that ends the read phase. It is presented with a one-cycle acknowledge while all strobes are already high, and it stays unchanged until the next read.
- R5: A write holds write-strobe low, with select low and drive-enable high, for N_WP = max(ceil(tWP), ceil(tDS)) cycles, which is 4 at a 4 ns clock. The driven nibble is the captured write data and stays constant throughout.
- R6: After the write strobe, select stays low for N_REC = max(1, ceil(tWC) - N_WP) further cycles, which is 1 at a 4 ns clock. The acknowledge follows on the edge that raises select.
- R7: Drive-enable is high only while write-strobe and select are low and output-enable is high. It falls on the same edge that raises write-strobe, and it is never high while the RAM drives the bus or within the RAM's float time after output-enable rises.
- R8: A write that directly follows a read, with no write in between, first spends N_TA = ceil(tWHZ) cycles (2 at a 4 ns clock) with select low and the other strobes high and drive-enable low. A write that follows reset or another write has no such phase.
- R9: Each request produces exactly one acknowledge. While a request is being served, the block ignores the request inputs, including a held valid and changed address or data. It accepts the next request only in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write nibble |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 4 | Captured read nibble |
| ram_addr | output | 18 | RAM address pins |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_o | output | 4 | Nibble driven toward the RAM |
| ram_dq_oe | output | 1 | Drive-enable for the data pad |
| ram_dq_i | input | 4 | Nibble received from the RAM |

## Verification
A sequencer stuck in the wrong phase, or a phase counter loaded with the wrong value, shows up at the RAM pins within one access. It appears as a strobe run one or more cycles too short or too long, or as a missing or duplicated acknowledge. A stale direction flag shows as a missing or spurious turnaround gap in front of the next write. If drive-enable falls too late, or the block drives too early after a read, the bus is contended, and the bench's float-window model flags that on the first cycle of overlap. If the read nibble is sampled too early, the bench's RAM model returns inverted data before its access time, so the wrong value appears at the acknowledge of that same read.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WPULSE,
    ST_WREC,
    ST_ACK
  } seq_state_t;

  // whole cycles covering a nanosecond minimum, never fewer than one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_io_regs.sv
`timescale 1ns/1ps
module asram_io_regs #(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rd_sample,
  input  logic [DW-1:0] ram_dq_i,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_o,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_dq_o <= '0;
    end else if (accept) begin
      ram_addr <= req_addr;
      ram_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_data <= '0;
    else if (rd_sample) rd_data <= ram_dq_i;
  end
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CW    = 3,
  parameter int unsigned N_RD  = 5,
  parameter int unsigned N_TA  = 2,
  parameter int unsigned N_WP  = 4,
  parameter int unsigned N_REC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          timer_zero,
  output logic          timer_load,
  output logic [CW-1:0] timer_val,
  output logic          accept,
  output logic          rd_sample,
  output logic          wr_pulse_end,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic          ack
);
  localparam logic [CW-1:0] LD_RD  = CW'(N_RD - 1);
  localparam logic [CW-1:0] LD_TA  = CW'(N_TA - 1);
  localparam logic [CW-1:0] LD_WP  = CW'(N_WP - 1);
  localparam logic [CW-1:0] LD_REC = CW'(N_REC - 1);

  seq_state_t state_q;
  logic       last_rd_q;

  always_comb begin
    accept       = (state_q == ST_IDLE) && req_valid;
    rd_sample    = (state_q == ST_READ) && timer_zero;
    wr_pulse_end = (state_q == ST_WPULSE) && timer_zero;
    timer_load   = 1'b0;
    timer_val    = '0;
    if (accept) begin
      timer_load = 1'b1;
      if (!req_write)     timer_val = LD_RD;
      else if (last_rd_q) timer_val = LD_TA;
      else                timer_val = LD_WP;
    end else if (state_q == ST_TURN && timer_zero) begin
      timer_load = 1'b1;
      timer_val  = LD_WP;
    end else if (wr_pulse_end) begin
      timer_load = 1'b1;
      timer_val  = LD_REC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ce_n <= 1'b0;
            if (!req_write) begin
              oe_n      <= 1'b0;
              last_rd_q <= 1'b1;
              state_q   <= ST_READ;
            end else if (last_rd_q) begin
              state_q <= ST_TURN;
            end else begin
              we_n    <= 1'b0;
              dq_oe   <= 1'b1;
              state_q <= ST_WPULSE;
            end
          end
        end
        ST_READ: begin
          if (timer_zero) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            ack     <= 1'b1;
            state_q <= ST_ACK;
          end
        end
        ST_TURN: begin
          if (timer_zero) begin
            we_n    <= 1'b0;
            dq_oe   <= 1'b1;
            state_q <= ST_WPULSE;
          end
        end
        ST_WPULSE: begin
          if (timer_zero) begin
            we_n      <= 1'b1;
            dq_oe     <= 1'b0;
            last_rd_q <= 1'b0;
            state_q   <= ST_WREC;
          end
        end
        ST_WREC: begin
          if (timer_zero) begin
            ce_n    <= 1'b1;
            ack     <= 1'b1;
            state_q <= ST_ACK;
          end
        end
        ST_ACK:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW         = 18,
  parameter int unsigned DW         = 4,
  parameter int unsigned CLK_NS     = 4,
  parameter int unsigned T_RC_NS    = 17,
  parameter int unsigned T_AA_NS    = 17,
  parameter int unsigned T_OE_NS    = 9,
  parameter int unsigned T_WP_NS    = 13,
  parameter int unsigned T_WC_NS    = 17,
  parameter int unsigned T_DS_NS    = 9,
  parameter int unsigned T_FLOAT_NS = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_i
);
  localparam int unsigned N_RD  = max2(ns_to_cyc(T_RC_NS, CLK_NS),
                                       max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int unsigned N_WP  = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int unsigned N_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_REC = (N_WC > N_WP + 1) ? (N_WC - N_WP) : 1;
  localparam int unsigned N_TA  = ns_to_cyc(T_FLOAT_NS, CLK_NS);
  localparam int unsigned N_MAX = max2(max2(N_RD, N_WP), max2(N_REC, N_TA));
  localparam int unsigned CW    = cnt_width(N_MAX);

  // internal events, named for the bound checker
  logic          accept;
  logic          rd_sample;
  logic          wr_pulse_end;
  logic          timer_load;
  logic          timer_zero;
  logic [CW-1:0] timer_val;

  asram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .zero     (timer_zero)
  );

  asram_seq #(
    .CW(CW), .N_RD(N_RD), .N_TA(N_TA), .N_WP(N_WP), .N_REC(N_REC)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .timer_zero   (timer_zero),
    .timer_load   (timer_load),
    .timer_val    (timer_val),
    .accept       (accept),
    .rd_sample    (rd_sample),
    .wr_pulse_end (wr_pulse_end),
    .ce_n         (ram_ce_n),
    .oe_n         (ram_oe_n),
    .we_n         (ram_we_n),
    .dq_oe        (ram_dq_oe),
    .ack          (ack)
  );

  asram_io_regs #(.AW(AW), .DW(DW)) u_io (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_sample (rd_sample),
    .ram_dq_i  (ram_dq_i),
    .ram_addr  (ram_addr),
    .ram_dq_o  (ram_dq_o),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic [AW-1:0] ram_addr,
  input logic          ram_ce_n,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic [DW-1:0] ram_dq_o,
  input logic          ram_dq_oe,
  input logic          rd_sample,
  input logic          wr_pulse_end
);
  p_standby_r2: assert property (@(posedge clk) disable iff (rst)
    ram_ce_n |-> (ram_oe_n && ram_we_n && !ram_dq_oe));

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> (ram_we_n && !ram_ce_n));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

  p_sample_in_read_r4: assert property (@(posedge clk) disable iff (rst)
    rd_sample |-> (!ram_ce_n && !ram_oe_n));

  p_ack_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ack |-> ram_ce_n);

  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_dq_o));

  p_drive_window_r7: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (!ram_we_n && ram_oe_n && !ram_ce_n));

  p_release_with_we_r7: assert property (@(posedge clk) disable iff (rst)
    wr_pulse_end |=> (ram_we_n && !ram_dq_oe && !ram_ce_n));

  p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ack          (ack),
  .ram_addr     (ram_addr),
  .ram_ce_n     (ram_ce_n),
  .ram_oe_n     (ram_oe_n),
  .ram_we_n     (ram_we_n),
  .ram_dq_o     (ram_dq_o),
  .ram_dq_oe    (ram_dq_oe),
  .rd_sample    (rd_sample),
  .wr_pulse_end (wr_pulse_end)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
  localparam int CLK_NS   = 4;
  localparam int T_WP_NS  = 13;
  localparam int RD_VALID = (17 + CLK_NS - 1) / CLK_NS - 1;
  localparam int FLOAT_C  = (7 + CLK_NS - 1) / CLK_NS;
  localparam int E_RD = 5, E_WP = 4, E_REC = 1, E_TA = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        ack;
  logic [3:0]  rd_data;
  logic [17:0] ram_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [3:0]  dq_o;
  logic [3:0]  dq_i = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
    .ram_addr(ram_addr), .ram_ce_n(ce_n), .ram_oe_n(oe_n), .ram_we_n(we_n),
    .ram_dq_o(dq_o), .ram_dq_oe(dq_oe), .ram_dq_i(dq_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // RAM model: sparse store, unwritten words follow a pattern
  logic [3:0] ram_mem [logic [17:0]];
  function automatic logic [3:0] pat(input logic [17:0] a);
    return a[3:0] ^ a[17:14];
  endfunction
  function automatic logic [3:0] ram_rd(input logic [17:0] a);
    return ram_mem.exists(a) ? ram_mem[a] : pat(a);
  endfunction

  int ce_run = 0, rd_run = 0, we_run = 0, turn_run = 0, float_left = 0;
  int last_ce = 0, last_rd = 0, last_we = 0, last_turn = 0;
  int wcnt = 0;
  bit wdrv = 1'b1;
  logic [17:0] wa;
  logic [3:0]  wd;

  always @(negedge clk) begin
    bit drv;
    drv = !ce_n && !oe_n && we_n;
    if (dq_oe) check(!(drv || float_left > 0), "R7 contention", float_left, 0);
    float_left = drv ? FLOAT_C : (float_left > 0 ? float_left - 1 : 0);
    if (rst) begin
      ce_run = 0; rd_run = 0; we_run = 0; turn_run = 0; wcnt = 0; wdrv = 1'b1;
    end else begin
      if (!ce_n) begin
        ce_run++;
        if (!oe_n) rd_run++;
        if (!we_n) we_run++;
        if (we_n && oe_n && we_run == 0) turn_run++;
      end else if (ce_run > 0) begin
        last_ce = ce_run; last_rd = rd_run; last_we = we_run; last_turn = turn_run;
        ce_run = 0; rd_run = 0; we_run = 0; turn_run = 0;
      end
      if (!ce_n && !we_n) begin
        wcnt++; wa = ram_addr; wd = dq_o; wdrv = wdrv && dq_oe;
      end else if (wcnt > 0) begin
        check(wcnt * CLK_NS >= T_WP_NS, "R5 pulse ns", wcnt * CLK_NS, T_WP_NS);
        check(wdrv, "R5 driven during strobe", wdrv, 1);
        ram_mem[wa] = wd;
        wcnt = 0; wdrv = 1'b1;
      end
    end
    dq_i = (rd_run >= RD_VALID) ? ram_rd(ram_addr) : ~ram_rd(ram_addr);
  end

  // entry: {write, addr, wdata, expected read}
  localparam int NV = 9;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 18'h00010, 4'hA, 4'h0},
    {1'b1, 18'h3FFFF, 4'h5, 4'h0},
    {1'b0, 18'h00010, 4'h0, 4'hA},
    {1'b1, 18'h20000, 4'hC, 4'h0},
    {1'b0, 18'h3FFFF, 4'h0, 4'h5},
    {1'b0, 18'h12345, 4'h0, 4'h1},
    {1'b1, 18'h12345, 4'h3, 4'h0},
    {1'b0, 18'h20000, 4'h0, 4'hC},
    {1'b0, 18'h12345, 4'h0, 4'h3}
  };

  bit prev_read = 1'b0;

  task automatic run_op(input bit wr, input logic [17:0] a, input logic [3:0] d, input logic [3:0] exp);
    int n, extra;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_addr = ~a; req_wdata = ~d;          // R9: must be ignored while busy
    n = 0;
    while (!ack && n < 60) begin @(negedge clk); n++; end
    check(ack, "R9 ack arrives", ack, 1);
    req_valid = 1'b0;
    check(ce_n && oe_n && we_n, "R4 strobes high at ack", ce_n, 1);
    if (!wr) check(rd_data == exp, "R4 read data", rd_data, exp);
    @(posedge clk); #1;
    if (!wr) begin
      check(last_rd == E_RD, "R3 read phase cycles", last_rd, E_RD);
      check(last_ce == E_RD, "R3 select cycles", last_ce, E_RD);
    end else begin
      check(last_we == E_WP, "R5 strobe cycles", last_we, E_WP);
      check(last_turn == (prev_read ? E_TA : 0), "R8 turnaround", last_turn, prev_read ? E_TA : 0);
      check(last_ce == E_WP + E_REC + (prev_read ? E_TA : 0), "R6 write select cycles",
            last_ce, E_WP + E_REC + (prev_read ? E_TA : 0));
    end
    extra = 0;
    repeat (3) begin @(negedge clk); if (ack) extra++; end
    check(extra == 0, "R9 single ack", extra, 0);
    check(ce_n && oe_n && we_n && !dq_oe, "R2 idle standby", ce_n, 1);
    if (!wr) check(rd_data == exp, "R4 read data held", rd_data, exp);
    prev_read = !wr;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ce_n && oe_n && we_n, "R1 reset strobes", {ce_n, oe_n, we_n}, 7);
    check(!dq_oe && !ack && rd_data == 4'h0, "R1 reset outputs", {dq_oe, ack, rd_data}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(ce_n && !dq_oe, "R2 idle after reset", ce_n, 1);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][26], VEC[i][25:8], VEC[i][7:4], VEC[i][3:0]);

    // R1: reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00010;
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(!ce_n && !oe_n, "R3 read under way", ce_n, 0);
    rst = 1'b1;
    @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe, "R1 mid-cycle reset strobes", {ce_n, oe_n}, 3);
    check(rd_data == 4'h0 && !ack, "R1 mid-cycle reset data", rd_data, 0);
    rst = 1'b0;
    prev_read = 1'b0;
    repeat (2) @(negedge clk);
    // R8: write after reset gets no turnaround, even though a read was cut short
    run_op(1'b1, 18'h00001, 4'h9, 4'h0);
    run_op(1'b1, 18'h00002, 4'h6, 4'h0);
    run_op(1'b0, 18'h00001, 4'h0, 4'h9);
    run_op(1'b0, 18'h00002, 4'h0, 4'h6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule